// File: doc/BRIEF.md
# Flash Read Wait-State Controller

This block sits between a system bus and an on-chip flash read path and decides how many cycles each read access is held before its data may be returned. It keeps one 32-bit control word that selects between a manually programmed flash wait count and an automatic count derived from the flash access time. The control word can add an extra address wait state and can choose how hits in a separate read buffer are timed. Every incoming read request carries a flag telling whether it hit that buffer or must go to the flash array.

Software programs the control word through a small register port that carries a privilege indicator. The control word can also be locked so that only privileged masters may reach it. The read side accepts one request at a time. It keeps its ready output low for the computed number of wait cycles, then raises ready for a single cycle. The automatic term, meaning the access time plus 5 ns rounded up to whole clocks, is supplied as the parameter `ACC_CYC`.

Top module: `flash_wait_ctrl`

## Requirements
- R1: After reset the control word reads 0x00008000, so automatic timing is enabled and every other field is zero.
- R2: Only bits 19:16 (buffer mode), 15 (automatic enable), 14 (address wait), 11:8 (manual flash count) and 2 (privilege lock) are implemented, which gives the mask 0x000FCF04. All other bits ignore writes and read as zero.
- R3: With bit 15 clear, a read that goes to the flash array waits bit 14 plus the value of bits 11:8, a total of 0 to 16 cycles.
- R4: With bit 15 set, a read that goes to the flash array waits bit 14 plus `ACC_CYC` plus 2 cycles.
- R5: A read-buffer hit while the buffer mode is 0 completes with zero wait cycles.
- R6: A read-buffer hit while the buffer mode is 1 waits bit 14 plus bits 11:8, whatever the state of bit 15.
- R7: Buffer mode values 2 to 15 behave as mode 0, so buffer hits get zero wait cycles.
- R8: While bit 2 is set, an access with `reg_priv` low is blocked. A blocked write leaves the word unchanged, a blocked read returns zero, and either one raises `reg_err` for one cycle. While bit 2 is clear, accesses are accepted whatever the value of `reg_priv`.
- R9: After a request is accepted on a clock edge, `rd_ready` stays low for exactly the computed wait count of cycles and is then high for one cycle. `rd_busy` is high from acceptance through that ready cycle. Requests presented while busy are ignored.
- R10: Only register offset 0 is decoded. Reads at any other offset return zero without an error, and writes there change nothing.
- R11: Read data appears on `reg_rdata` in the cycle after the read strobe and is zero in every cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_priv | input | 1 | Access is privileged |
| reg_rdata | output | 32 | Registered read data |
| reg_err | output | 1 | One-cycle flag for a blocked access |
| req_valid | input | 1 | Read request |
| req_buf_hit | input | 1 | Request hit the read buffer |
| rd_ready | output | 1 | One-cycle completion pulse |
| rd_busy | output | 1 | A request is in progress |

## Verification
The bench builds the block with `ACC_CYC` = 3 and `ADDR_W` = 4. With these values the automatic count (5, or 6 with the address wait) differs from every manual setting used, so a mix-up between the two sources shows up as a wrong cycle count. The 4-bit offset lets the bench probe undecoded offsets. The manual count is taken to its top value of 15 with the address wait set, which exercises the widest wait the counter must hold.

// File: rtl/fwc_pkg.sv
package fwc_pkg;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] CTRL_RST  = 32'h0000_8000;
  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h000F_CF04;

  localparam int BIT_LOCK  = 2;
  localparam int BIT_ADDRW = 14;
  localparam int BIT_AUTO  = 15;
  localparam int FCNT_LSB  = 8;
  localparam int BMODE_LSB = 16;

  typedef struct packed {
    logic       auto_en;
    logic       addr_ws;
    logic [3:0] flash_ws;
    logic [3:0] buf_mode;
    logic       lock;
  } ctrl_fields_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } stall_st_e;
endpackage

// File: rtl/fwc_ctrl_regs.sv
module fwc_ctrl_regs
  import fwc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              priv,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  output ctrl_fields_t      fields
);
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              err_q, err_d;
  logic              sel, allowed, ctrl_en;

  always_comb begin
    sel     = (addr == '0);
    allowed = priv || !ctrl_q[BIT_LOCK];
    ctrl_en = wr_en && sel && allowed;
    ctrl_d  = wdata & CTRL_MASK;
    rdata_d = (rd_en && sel && allowed) ? ctrl_q : '0;
    err_d   = (wr_en || rd_en) && sel && !allowed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign rdata = rdata_q;
  assign err   = err_q;
  assign fields.auto_en  = ctrl_q[BIT_AUTO];
  assign fields.addr_ws  = ctrl_q[BIT_ADDRW];
  assign fields.flash_ws = ctrl_q[FCNT_LSB +: 4];
  assign fields.buf_mode = ctrl_q[BMODE_LSB +: 4];
  assign fields.lock     = ctrl_q[BIT_LOCK];

  assert_blocked_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !priv && ctrl_q[BIT_LOCK]) |=> $stable(ctrl_q));
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~CTRL_MASK) == '0);
  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(wr_en || rd_en));
  assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0));
endmodule

// File: rtl/fwc_wait_calc.sv
module fwc_wait_calc
  import fwc_pkg::*;
#(
  parameter int ACC_CYC = 3,
  parameter int CNT_W   = 5
) (
  input  ctrl_fields_t     fields,
  input  logic             buf_hit,
  output logic [CNT_W-1:0] wait_cnt
);
  localparam logic [CNT_W-1:0] AUTO_TERM = CNT_W'(ACC_CYC + 2);

  logic [CNT_W-1:0] manual_cnt, miss_cnt, hit_cnt;
  logic             det_hit;

  always_comb begin
    manual_cnt = CNT_W'(fields.addr_ws) + CNT_W'(fields.flash_ws);
    miss_cnt   = fields.auto_en ? (CNT_W'(fields.addr_ws) + AUTO_TERM) : manual_cnt;
    det_hit    = (fields.buf_mode == 4'd1);
    hit_cnt    = det_hit ? manual_cnt : '0;
    wait_cnt   = buf_hit ? hit_cnt : miss_cnt;
  end

  always_comb begin
    if (buf_hit && fields.buf_mode != 4'd1) begin
      assert_fast_hit_R7: assert (wait_cnt == '0);
    end
  end
endmodule

// File: rtl/fwc_stall_seq.sv
module fwc_stall_seq
  import fwc_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CNT_W-1:0] wait_cnt,
  output logic             rd_ready,
  output logic             busy
);
  stall_st_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (wait_cnt == '0) begin
            state_d = ST_DONE;
          end else begin
            state_d = ST_WAIT;
            cnt_d   = wait_cnt;
            cnt_en  = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
        if (cnt_q == CNT_W'(1)) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign rd_ready = (state_q == ST_DONE);
  assign busy     = (state_q != ST_IDLE);

  assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |=> !rd_ready);
  assert_busy_from_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
  assert_wait_count_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (cnt_q != '0));
endmodule

// File: rtl/flash_wait_ctrl.sv
module flash_wait_ctrl
  import fwc_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int ACC_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_priv,
  output logic [31:0]       reg_rdata,
  output logic              reg_err,
  input  logic              req_valid,
  input  logic              req_buf_hit,
  output logic              rd_ready,
  output logic              rd_busy
);
  localparam int MAX_WAIT = (ACC_CYC + 3 > 16) ? (ACC_CYC + 3) : 16;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_n_i;
  ctrl_fields_t     fields;
  logic [CNT_W-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  fwc_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n_i), .wr_en(reg_wr), .rd_en(reg_rd),
    .addr(reg_addr), .wdata(reg_wdata), .priv(reg_priv),
    .rdata(reg_rdata), .err(reg_err), .fields(fields)
  );

  fwc_wait_calc #(.ACC_CYC(ACC_CYC), .CNT_W(CNT_W)) u_calc (
    .fields(fields), .buf_hit(req_buf_hit), .wait_cnt(wait_cnt)
  );

  fwc_stall_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n_i), .req_valid(req_valid),
    .wait_cnt(wait_cnt), .rd_ready(rd_ready), .busy(rd_busy)
  );

  assert_zero_wait_next_R5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_valid && !rd_busy && wait_cnt == '0) |=> rd_ready);
endmodule

// File: tb/flash_wait_ctrl_bench.sv
module flash_wait_ctrl_bench;
  localparam int ACC = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd, reg_priv;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        reg_err;
  logic        req_valid, req_buf_hit;
  logic        rd_ready, rd_busy;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  flash_wait_ctrl #(.ADDR_W(4), .ACC_CYC(ACC)) u_flash_wait_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_priv(reg_priv),
    .reg_rdata(reg_rdata), .reg_err(reg_err), .req_valid(req_valid),
    .req_buf_hit(req_buf_hit), .rd_ready(rd_ready), .rd_busy(rd_busy)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_reg, m_rdata;
  logic        m_err;
  int          m_phase, m_rem;

  function automatic int wait_of(input logic [31:0] w, input logic hit);
    int adr  = int'(w[14]);
    int fcnt = int'(w[11:8]);
    if (hit) return (w[19:16] == 4'd1) ? adr + fcnt : 0;
    return w[15] ? adr + ACC + 2 : adr + fcnt;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg = 32'h0000_8000; m_rdata = 0; m_err = 0; m_phase = 0; m_rem = 0;
    end else begin
      logic [31:0] old;
      logic ok, hit_sel;
      int n;
      old = m_reg;
      hit_sel = (reg_addr == 4'd0);
      ok = reg_priv || !old[2];
      m_rdata = (reg_rd && hit_sel && ok) ? old : 32'h0;
      m_err = (reg_wr || reg_rd) && hit_sel && !ok;
      if (reg_wr && hit_sel && ok) m_reg = reg_wdata & 32'h000F_CF04;
      case (m_phase)
        0: if (req_valid) begin
             n = wait_of(old, req_buf_hit);
             if (n == 0) m_phase = 2;
             else begin m_phase = 1; m_rem = n; end
           end
        1: begin m_rem--; if (m_rem == 0) m_phase = 2; end
        default: m_phase = 0;
      endcase
    end
  end

  bit running = 0;
  always @(negedge clk) begin
    if (running) begin
      chk("R9 rd_ready vs model", rd_ready, (m_phase == 2));
      chk("R9 rd_busy vs model", rd_busy, (m_phase != 0));
      chk("R11 reg_rdata vs model", reg_rdata, m_rdata);
      chk("R8 reg_err vs model", reg_err, m_err);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic p);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d; reg_priv = p;
    @(negedge clk); reg_wr = 0; reg_addr = 0; reg_wdata = 0; reg_priv = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic p, input logic [31:0] exp_d,
                    input logic exp_e, input string tag);
    @(negedge clk); reg_rd = 1; reg_addr = a; reg_priv = p;
    @(negedge clk); reg_rd = 0; reg_addr = 0; reg_priv = 0;
    chk(tag, reg_rdata, exp_d);
    chk(tag, reg_err, exp_e);
  endtask

  task automatic measure(input logic hit, input int exp_n, input bit hold, input string tag);
    int n = 0;
    @(negedge clk); req_valid = 1; req_buf_hit = hit;
    @(negedge clk);
    if (!hold) begin req_valid = 0; req_buf_hit = 0; end
    while (!rd_ready && n < 100) begin n++; @(negedge clk); end
    req_valid = 0; req_buf_hit = 0;
    chk(tag, n, exp_n);
    @(negedge clk);
    chk(tag, rd_busy, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0; reg_priv = 0;
    req_valid = 0; req_buf_hit = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    running = 1;
    chk("R9 idle after reset", rd_busy, 0);
    rd(4'd0, 1'b0, 32'h0000_8000, 1'b0, "R1 reset value");
    measure(1'b0, ACC + 2, 1'b0, "R4 auto miss after reset");
    wr(4'd0, 32'hFFFF_FFFF, 1'b1);
    rd(4'd0, 1'b1, 32'h000F_CF04, 1'b0, "R2 implemented mask");
    wr(4'd0, 32'h0000_0704, 1'b1);
    measure(1'b0, 7, 1'b0, "R3 manual miss fcnt=7");
    wr(4'd0, 32'h0000_0000, 1'b0);
    rd(4'd0, 1'b0, 32'h0, 1'b1, "R8 locked unprivileged read");
    rd(4'd0, 1'b1, 32'h0000_0704, 1'b0, "R8 locked write ignored");
    wr(4'd0, 32'h0000_4A00, 1'b1);
    measure(1'b0, 11, 1'b0, "R3 manual miss addr+10");
    measure(1'b1, 0, 1'b0, "R5 hit mode 0");
    wr(4'd0, 32'h0001_4A00, 1'b0);
    measure(1'b1, 11, 1'b0, "R6 hit mode 1 manual");
    wr(4'd0, 32'h0001_CA00, 1'b0);
    measure(1'b0, 1 + ACC + 2, 1'b0, "R4 auto miss with addr wait");
    measure(1'b1, 11, 1'b0, "R6 hit mode 1 auto on");
    wr(4'd0, 32'h0002_4F00, 1'b0);
    measure(1'b1, 0, 1'b0, "R7 hit mode 2");
    measure(1'b0, 16, 1'b0, "R3 max manual wait");
    rd(4'd0, 1'b0, 32'h0002_4F00, 1'b0, "R8 unlocked unprivileged read");
    wr(4'd3, 32'h0000_0000, 1'b1);
    rd(4'd3, 1'b1, 32'h0, 1'b0, "R10 other offset reads zero");
    rd(4'd0, 1'b1, 32'h0002_4F00, 1'b0, "R10 other offset write ignored");
    measure(1'b0, 16, 1'b1, "R9 held request while busy");
    repeat (3) @(negedge clk);
    running = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule